// File: doc/BRIEF.md
# Hsiao SECDED 72/64 codec

This block protects a 64-bit word with 8 check bits using an odd-weight column code: every data bit is assigned a fixed 8-bit column pattern of weight three or five, and every check bit owns a single-bit column. On the write side it produces the 8 check bits for a data word. On the read side it takes the stored word and its stored check bits, forms the 8-bit syndrome, repairs any single flipped bit, and reports whether the word was clean, corrected or beyond repair.

Both paths are registered. A result appears one clock after its valid strobe and is held until the next strobe. The block sits between a memory controller's datapath and its storage. Scrubbing, writing corrected words back and the memory interface itself belong to the surrounding logic.

Top module: `hsiao_secded_codec`

## Requirements
- R1: One cycle after `enc_valid_i`, `enc_valid_o` is 1 and `enc_check_o` bit k is the XOR of all data bits whose column has bit k set.
- R2: A word whose check bits match its data gives syndrome 0, both flags 0 and the data unchanged.
- R3: A single flipped data bit i gives a syndrome equal to column i. Examples are bit 0 = 0xF4, bit 1 = 0xF1, bit 2 = 0xEC, bit 31 = 0x8A, bit 32 = 0x75, bit 62 = 0x0E and bit 63 = 0x0B. The output data has that bit restored and `dec_ce_o` = 1.
- R4: A single flipped check bit j gives syndrome (1 << j) and `dec_ce_o` = 1, with the data passed through unchanged.
- R5: Any nonzero syndrome of even weight sets `dec_ue_o` = 1 and passes the data unchanged. This covers any two flipped bits and the pattern 0x03.
- R6: An odd-weight syndrome that matches no data column and no single check bit (for example 0x07 or 0x7F) sets `dec_ue_o` = 1 and passes the data unchanged.
- R7: `dec_ce_o` and `dec_ue_o` are never both 1, and either flag implies a nonzero `dec_syndrome_o`.
- R8: `dec_valid_o` is 1 exactly one cycle after `dec_valid_i`. Without a strobe, the decode outputs keep their last values.
- R9: While reset is held, all valid outputs, flags, check bits, syndrome and data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_valid_i | input | 1 | Encode request strobe |
| enc_data_i | input | 64 | Word to encode |
| enc_valid_o | output | 1 | Encode result valid |
| enc_check_o | output | 8 | Generated check bits |
| dec_valid_i | input | 1 | Decode request strobe |
| dec_data_i | input | 64 | Stored data word |
| dec_check_i | input | 8 | Stored check bits |
| dec_valid_o | output | 1 | Decode result valid |
| dec_data_o | output | 64 | Corrected data word |
| dec_syndrome_o | output | 8 | Syndrome of the stored word |
| dec_ce_o | output | 1 | Single error corrected |
| dec_ue_o | output | 1 | Uncorrectable error detected |

## Verification
The encoder is tried with zero, all ones and random words. Each result is compared with parity sums over the column table, which confirms the row masks bit by bit.

The decoder is fed clean codewords, which separate a true zero syndrome from false alarms. It is also fed every single data-bit flip and every single check-bit flip. These show that each of the 72 columns is decoded to the right position, and that check-bit hits leave the data alone.

Random double flips across data and check bits, the directed 0x03 pattern, and the odd unmatched patterns 0x07 and 0x7F are used to separate the uncorrectable path from a miscorrection. A quiet cycle with changed inputs shows that the outputs hold between strobes.

// File: rtl/secded_pkg.sv
package secded_pkg;
    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [CHK_W-1:0]  chk_t;

    typedef struct packed {
        word_t data;
        chk_t  syn;
        logic  ce;
        logic  ue;
    } dec_res_t;

    // Syndrome produced by a lone error on each data bit, index 0 first.
    localparam chk_t COLUMN_TAB [DATA_W] = '{
        8'hF4, 8'hF1, 8'hEC, 8'hEA, 8'hE9, 8'hE6, 8'hE5, 8'hE3,
        8'hDC, 8'hDA, 8'hD9, 8'hD6, 8'hD5, 8'hD3, 8'hCE, 8'hCB,
        8'hB5, 8'hB0, 8'hAD, 8'hAB, 8'hA8, 8'hA7, 8'hA4, 8'hA2,
        8'h9D, 8'h9B, 8'h98, 8'h97, 8'h94, 8'h92, 8'h8F, 8'h8A,
        8'h75, 8'h70, 8'h6D, 8'h6B, 8'h68, 8'h67, 8'h64, 8'h62,
        8'h5E, 8'h5B, 8'h58, 8'h57, 8'h54, 8'h52, 8'h4F, 8'h4A,
        8'h34, 8'h31, 8'h2C, 8'h2A, 8'h29, 8'h26, 8'h25, 8'h23,
        8'h1C, 8'h1A, 8'h19, 8'h16, 8'h15, 8'h13, 8'h0E, 8'h0B
    };

    // Data bits that feed check bit k.
    function automatic word_t row_mask(input int k);
        word_t m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = COLUMN_TAB[i][k];
        end
        return m;
    endfunction
endpackage

// File: rtl/ecc_check_gen.sv
module ecc_check_gen
    import secded_pkg::*;
(
    input  word_t data,
    output chk_t  chk
);
    for (genvar k = 0; k < CHK_W; k++) begin : g_row
        localparam word_t MASK = row_mask(k);
        assign chk[k] = ^(data & MASK);
    end
endmodule

// File: rtl/ecc_corrector.sv
module ecc_corrector
    import secded_pkg::*;
(
    input  word_t    data,
    input  chk_t     syn,
    output dec_res_t res
);
    word_t data_hit;
    chk_t  chk_hit;
    logic  any_hit;

    for (genvar i = 0; i < DATA_W; i++) begin : g_dcol
        assign data_hit[i] = (syn == COLUMN_TAB[i]);
    end

    for (genvar j = 0; j < CHK_W; j++) begin : g_ccol
        localparam chk_t UNIT = chk_t'(1) << j;
        assign chk_hit[j] = (syn == UNIT);
    end

    assign any_hit = (|data_hit) | (|chk_hit);

    always_comb begin
        res.data = data ^ data_hit;
        res.syn  = syn;
        res.ce   = any_hit;
        res.ue   = (syn != '0) && !any_hit;
    end
endmodule

// File: rtl/hsiao_secded_codec.sv
module hsiao_secded_codec
    import secded_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enc_valid_i,
    input  logic [63:0] enc_data_i,
    output logic        enc_valid_o,
    output logic [7:0]  enc_check_o,
    input  logic        dec_valid_i,
    input  logic [63:0] dec_data_i,
    input  logic [7:0]  dec_check_i,
    output logic        dec_valid_o,
    output logic [63:0] dec_data_o,
    output logic [7:0]  dec_syndrome_o,
    output logic        dec_ce_o,
    output logic        dec_ue_o
);
    chk_t     enc_chk;
    chk_t     regen_chk;
    chk_t     syn;
    dec_res_t res;
    dec_res_t res_q;

    ecc_check_gen u_enc_gen (.data(enc_data_i), .chk(enc_chk));
    ecc_check_gen u_dec_gen (.data(dec_data_i), .chk(regen_chk));

    assign syn = dec_check_i ^ regen_chk;

    ecc_corrector u_corr (.data(dec_data_i), .syn(syn), .res(res));

    always_ff @(posedge clk) begin
        if (rst) begin
            enc_valid_o <= 1'b0;
            enc_check_o <= '0;
            dec_valid_o <= 1'b0;
            res_q       <= '0;
        end else begin
            enc_valid_o <= enc_valid_i;
            dec_valid_o <= dec_valid_i;
            if (enc_valid_i) enc_check_o <= enc_chk;
            if (dec_valid_i) res_q <= res;
        end
    end

    assign dec_data_o     = res_q.data;
    assign dec_syndrome_o = res_q.syn;
    assign dec_ce_o       = res_q.ce;
    assign dec_ue_o       = res_q.ue;
endmodule

// File: rtl/hsiao_secded_codec_chk.sv
module hsiao_secded_codec_chk (
    input logic        clk,
    input logic        rst,
    input logic        enc_valid_i,
    input logic        enc_valid_o,
    input logic        dec_valid_i,
    input logic [63:0] dec_data_i,
    input logic        dec_valid_o,
    input logic [63:0] dec_data_o,
    input logic [7:0]  dec_syndrome_o,
    input logic        dec_ce_o,
    input logic        dec_ue_o
);
    AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        enc_valid_i |=> enc_valid_o);  // R1
    AST_ZERO_SYN_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_o && dec_syndrome_o == 8'h00) |-> (!dec_ce_o && !dec_ue_o));  // R2
    AST_EVEN_SYN_UE: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_o && dec_syndrome_o != 8'h00 && !(^dec_syndrome_o)) |-> dec_ue_o);  // R5
    AST_UE_PASSES_DATA: assert property (@(posedge clk) disable iff (rst)
        dec_valid_i |=> (!dec_ue_o || dec_data_o == $past(dec_data_i)));  // R6
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(dec_ce_o && dec_ue_o));  // R7
    AST_FLAG_NEEDS_SYN: assert property (@(posedge clk) disable iff (rst)
        (dec_ce_o || dec_ue_o) |-> dec_syndrome_o != 8'h00);  // R7
    AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        dec_valid_i |=> dec_valid_o);  // R8
    AST_DEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !dec_valid_i |=> ($stable(dec_data_o) && $stable(dec_syndrome_o) && !dec_valid_o));  // R8
endmodule

bind hsiao_secded_codec hsiao_secded_codec_chk u_chk (
    .clk(clk), .rst(rst),
    .enc_valid_i(enc_valid_i), .enc_valid_o(enc_valid_o),
    .dec_valid_i(dec_valid_i), .dec_data_i(dec_data_i),
    .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
    .dec_syndrome_o(dec_syndrome_o), .dec_ce_o(dec_ce_o), .dec_ue_o(dec_ue_o)
);

// File: tb/sim_hsiao_secded_codec.sv
module sim_hsiao_secded_codec;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_valid_i = 1'b0;
    logic [63:0] enc_data_i = '0;
    logic        enc_valid_o;
    logic [7:0]  enc_check_o;
    logic        dec_valid_i = 1'b0;
    logic [63:0] dec_data_i = '0;
    logic [7:0]  dec_check_i = '0;
    logic        dec_valid_o;
    logic [63:0] dec_data_o;
    logic [7:0]  dec_syndrome_o;
    logic        dec_ce_o;
    logic        dec_ue_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hsiao_secded_codec u0 (.*);

    localparam logic [7:0] COL [64] = '{
        8'hF4, 8'hF1, 8'hEC, 8'hEA, 8'hE9, 8'hE6, 8'hE5, 8'hE3,
        8'hDC, 8'hDA, 8'hD9, 8'hD6, 8'hD5, 8'hD3, 8'hCE, 8'hCB,
        8'hB5, 8'hB0, 8'hAD, 8'hAB, 8'hA8, 8'hA7, 8'hA4, 8'hA2,
        8'h9D, 8'h9B, 8'h98, 8'h97, 8'h94, 8'h92, 8'h8F, 8'h8A,
        8'h75, 8'h70, 8'h6D, 8'h6B, 8'h68, 8'h67, 8'h64, 8'h62,
        8'h5E, 8'h5B, 8'h58, 8'h57, 8'h54, 8'h52, 8'h4F, 8'h4A,
        8'h34, 8'h31, 8'h2C, 8'h2A, 8'h29, 8'h26, 8'h25, 8'h23,
        8'h1C, 8'h1A, 8'h19, 8'h16, 8'h15, 8'h13, 8'h0E, 8'h0B
    };

    function automatic logic [7:0] ref_check(input logic [63:0] d);
        logic [7:0] c;
        c = '0;
        for (int k = 0; k < 8; k++)
            for (int i = 0; i < 64; i++)
                if (COL[i][k]) c[k] = c[k] ^ d[i];
        return c;
    endfunction

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_enc(input string tag, input logic [63:0] d);
        @(negedge clk);
        enc_valid_i = 1'b1; enc_data_i = d;
        @(negedge clk);
        enc_valid_i = 1'b0;
        check(tag, {71'd0, enc_valid_o, enc_check_o}, {71'd0, 1'b1, ref_check(d)});
    endtask

    // Compares {valid, data, syndrome, ce, ue}.
    task automatic run_dec(input string tag, input logic [63:0] d, input logic [7:0] c,
                           input logic [63:0] ed, input logic [7:0] es,
                           input logic ece, input logic eue);
        @(negedge clk);
        dec_valid_i = 1'b1; dec_data_i = d; dec_check_i = c;
        @(negedge clk);
        dec_valid_i = 1'b0;
        check(tag, {5'd0, dec_valid_o, dec_data_o, dec_syndrome_o, dec_ce_o, dec_ue_o},
                   {5'd0, 1'b1, ed, es, ece, eue});
        check({tag, "/R7"}, {79'd0, dec_ce_o & dec_ue_o}, 80'd0);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] d, e;
        logic [7:0]  c;
        int a, b, seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        // R9: reset state while reset is held
        check("R9", {5'd0, enc_valid_o, enc_check_o, dec_valid_o, dec_data_o, dec_syndrome_o,
                     dec_ce_o, dec_ue_o}, 80'd0);
        rst = 1'b0;

        // R1: encoder
        run_enc("R1 zero", 64'd0);
        run_enc("R1 ones", {64{1'b1}});
        for (int n = 0; n < 20; n++) run_enc("R1 random", rnd64());

        // R2: clean words
        run_dec("R2 zero", 64'd0, 8'd0, 64'd0, 8'd0, 1'b0, 1'b0);
        for (int n = 0; n < 20; n++) begin
            d = rnd64();
            run_dec("R2 clean", d, ref_check(d), d, 8'd0, 1'b0, 1'b0);
        end

        // R3: every single data-bit flip
        for (int i = 0; i < 64; i++) begin
            d = rnd64();
            e = d ^ (64'd1 << i);
            run_dec("R3 data flip", e, ref_check(d), d, COL[i], 1'b1, 1'b0);
        end
        run_dec("R3 bit0", 64'd1, 8'd0, 64'd0, 8'hF4, 1'b1, 1'b0);
        run_dec("R3 bit63", 64'd1 << 63, 8'd0, 64'd0, 8'h0B, 1'b1, 1'b0);

        // R4: every single check-bit flip
        for (int j = 0; j < 8; j++) begin
            d = rnd64();
            c = ref_check(d) ^ (8'd1 << j);
            run_dec("R4 check flip", d, c, d, 8'd1 << j, 1'b1, 1'b0);
        end

        // R5: double errors
        for (int n = 0; n < 30; n++) begin
            d = rnd64();
            a = $urandom_range(71, 0);
            b = (a + 1 + $urandom_range(70, 0)) % 72;
            e = d; c = ref_check(d);
            if (a < 64) e[a] = ~e[a]; else c[a-64] = ~c[a-64];
            if (b < 64) e[b] = ~e[b]; else c[b-64] = ~c[b-64];
            run_dec("R5 double", e, c, e,
                    ((a < 64) ? COL[a] : 8'd1 << (a-64)) ^ ((b < 64) ? COL[b] : 8'd1 << (b-64)),
                    1'b0, 1'b1);
        end
        d = rnd64();
        run_dec("R5 syn03", d, ref_check(d) ^ 8'h03, d, 8'h03, 1'b0, 1'b1);

        // R6: odd-weight patterns matching no column
        d = rnd64();
        run_dec("R6 syn07", d, ref_check(d) ^ 8'h07, d, 8'h07, 1'b0, 1'b1);
        d = rnd64();
        run_dec("R6 syn7F", d, ref_check(d) ^ 8'h7F, d, 8'h7F, 1'b0, 1'b1);

        // R8: hold without strobe
        d = rnd64();
        run_dec("R8 prime", d ^ 64'd4, ref_check(d), d, COL[2], 1'b1, 1'b0);
        @(negedge clk);
        dec_data_i = ~d; dec_check_i = 8'hFF;
        @(negedge clk);
        check("R8 hold", {5'd0, dec_valid_o, dec_data_o, dec_syndrome_o, dec_ce_o, dec_ue_o},
                         {5'd0, 1'b0, d, COL[2], 1'b1, 1'b0});

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule